// File: doc/BRIEF.md
# Burst Write Packet Segmenter

This block sits between a memory-mapped slave port and the transmit side of a PCI Express link. It takes burst writes of up to 512 bytes, one qword per beat with byte enables, and turns each burst into one or more memory-write request descriptors. Each descriptor carries the packet's byte address, its length in dwords, the byte enables of its first and last dword, and a flag that selects the 4DW (64-bit address) header form. The payload qwords of each packet follow its descriptor on a separate valid/ready stream. The address arriving on the slave port has already been translated, and it counts qwords.

A burst is first collected in full in a local beat store. The byte enables are checked as the beats arrive. A burst that breaks the byte-enable rules is reported on a one-cycle error pulse and dropped. A legal burst is cut into packets so that none crosses a 4 KByte address boundary and none carries more than the maximum payload size selected when the burst began. The controller is a state machine with five states. IDLE accepts the first beat. COLLECT accepts the remaining beats. ERR raises the error pulse. DESC offers the descriptor of the next packet. DATA streams that packet's qwords.

The transitions are as follows. IDLE goes to COLLECT on the first beat of a multi-beat burst, and to DESC or ERR on a single-beat burst. COLLECT goes to DESC or ERR on the final beat. ERR always goes to IDLE. DESC goes to DATA on the descriptor handshake. DATA goes back to DESC after the last qword of a packet when more beats remain, and to IDLE after the last packet.

Top module: `pcie_write_segmenter`

## Requirements
- R1: During and straight after reset, `avs_waitrequest`, `desc_valid`, `pl_valid` and `wr_err` are all low.
- R2: No packet crosses a 4 KByte boundary. When a burst spans such a boundary, the packet in progress ends at the boundary and the next packet starts exactly on it.
- R3: No packet carries more than the maximum payload size. `mps_sel` encodes 0 as 128 bytes, 1 as 256 bytes, 2 as 512 bytes and 3 as 128 bytes. It is sampled only with the first beat of a burst, so later changes to it do not affect that burst.
- R4: Packets appear in address order. Each descriptor is followed by exactly its payload qwords, in beat order, and `pl_last` is high only on the last qword of a packet. Consecutive packets of a burst have contiguous addresses.
- R5: Bursts of more than one beat follow a fixed dword rule. A packet's first dword byte enable is the low nibble of its first qword's enables. When the burst's final qword has an upper nibble of zero, the packet holding that qword loses one dword and its last dword enable is that qword's low nibble. Otherwise the last dword enable is the upper nibble of the packet's end qword.
- R6: A single-beat burst may carry any byte enables. With enables 0xF0-style (low nibble zero, high nibble nonzero), the packet address is advanced by 4 and the length is one dword. With a zero high nibble, the length is one dword. Any one-dword packet reports a last enable of 0.
- R7: `desc_4dw` is high exactly when bits [63:32] of the packet's byte address are nonzero. This is decided per packet, so a burst that crosses the 4 GByte line yields both header forms.
- R8: A multi-beat burst breaks the byte-enable rules when a non-final beat has enables other than 0xFF, or when the final beat's enables are zero or not a contiguous run starting at bit 0. Such a burst has all of its beats accepted without stalls, raises `wr_err` for one cycle in the cycle after its final beat, and produces no descriptor.
- R9: `avs_waitrequest` is high from the cycle after a burst's final beat until the last payload handshake of the burst (or until the error cycle ends). While `desc_ready` or `pl_ready` is low, the offered descriptor or payload qword is held stable.
- R10: For a legal burst, `desc_valid` rises in the first cycle after the final beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avs_write | input | 1 | Write beat valid |
| avs_qw_address | input | 61 | Translated qword address, sampled with the first beat |
| avs_burstcount | input | 7 | Beats in the burst (1 to 64), sampled with the first beat |
| avs_writedata | input | 64 | Beat data |
| avs_byteenable | input | 8 | Beat byte enables |
| avs_waitrequest | output | 1 | Beat not accepted this cycle |
| mps_sel | input | 2 | Maximum payload size select |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Descriptor taken |
| desc_addr | output | 64 | Packet byte address |
| desc_len_dw | output | 10 | Packet length in dwords |
| desc_first_be | output | 4 | First dword byte enables |
| desc_last_be | output | 4 | Last dword byte enables |
| desc_4dw | output | 1 | 64-bit address header form |
| pl_valid | output | 1 | Payload qword offered |
| pl_ready | input | 1 | Payload qword taken |
| pl_data | output | 64 | Payload qword |
| pl_last | output | 1 | Last qword of the packet |
| wr_err | output | 1 | Byte-enable rule violation pulse |

## Verification
A descriptor is due in the first cycle after the final beat is accepted, and the error pulse of a bad burst is due in that same cycle. Each payload qword is due in the cycle after the previous handshake on its stream. The bench applies stimulus a little after each rising edge and samples every output on the falling edge that follows. It checks the descriptor and error timing at the first falling edge after the final beat. It records handshakes on the falling edge before the edge that completes them, so that a ready pattern that stalls at random never shifts what it compares.

// File: rtl/pcie_wseg_pkg.sv
package pcie_wseg_pkg;
    localparam int QW_BITS = 64;
    localparam int QW_BE   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_ERR,
        ST_DESC,
        ST_DATA
    } seg_state_e;

    typedef struct packed {
        logic [QW_BE-1:0]   be;
        logic [QW_BITS-1:0] data;
    } beat_t;
endpackage

// File: rtl/pcie_wseg_becheck.sv
module pcie_wseg_becheck (
    input  logic       multi,
    input  logic       last,
    input  logic [7:0] be,
    output logic       ok
);
    logic prefix;

    always_comb begin
        prefix = (be != 8'h00) && ((be & (be + 8'd1)) == 8'h00);
        if (!multi) begin
            ok = 1'b1;
        end else if (last) begin
            ok = prefix;
        end else begin
            ok = (be == 8'hFF);
        end
    end
endmodule

// File: rtl/pcie_wseg_store.sv
module pcie_wseg_store #(
    parameter int DEPTH = 64,
    parameter int W     = 72,
    parameter int NRD   = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [IDX_W-1:0]          waddr,
    input  logic [W-1:0]              wdata,
    input  logic [NRD-1:0][IDX_W-1:0] raddr,
    output logic [NRD-1:0][W-1:0]     rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/pcie_wseg_split.sv
module pcie_wseg_split #(
    parameter int CNT_W       = 7,
    parameter int BOUND_BYTES = 4096,
    localparam int OFS_W     = $clog2(BOUND_BYTES),
    localparam int BND_BEATS = BOUND_BYTES / 8,
    localparam int ROOM_W    = $clog2(BND_BEATS) + 1,
    localparam int CW        = (ROOM_W > CNT_W) ? ROOM_W : CNT_W
) (
    input  logic [OFS_W-4:0] qw_ofs,
    input  logic [CNT_W-1:0] beats_left,
    input  logic [CNT_W-1:0] cap_beats,
    output logic [CNT_W-1:0] pkt_beats
);
    logic [CW-1:0] room;
    logic [CW-1:0] lft;
    logic [CW-1:0] cap;
    logic [CW-1:0] m1;
    logic [CW-1:0] res;

    always_comb begin
        room = CW'(BND_BEATS) - CW'(qw_ofs);
        lft  = CW'(beats_left);
        cap  = CW'(cap_beats);
        m1   = (lft < cap) ? lft : cap;
        res  = (room < m1) ? room : m1;
        pkt_beats = CNT_W'(res);
    end
endmodule

// File: rtl/pcie_wseg_desc.sv
module pcie_wseg_desc #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 7,
    parameter int LEN_W  = 10
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  pkt_beats,
    input  logic              single,
    input  logic              final_pkt,
    input  logic [7:0]        be_first,
    input  logic [7:0]        be_end,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic [LEN_W-1:0]  len_dw,
    output logic [3:0]        first_be,
    output logic [3:0]        last_be,
    output logic              hdr4
);
    logic drop_lo;
    logic drop_hi;

    always_comb begin
        drop_lo  = single && (be_first[3:0] == 4'h0) && (be_first[7:4] != 4'h0);
        drop_hi  = final_pkt && (be_end[7:4] == 4'h0);
        len_dw   = LEN_W'({pkt_beats, 1'b0}) - LEN_W'(drop_lo) - LEN_W'(drop_hi);
        pkt_addr = base_addr + (drop_lo ? ADDR_W'(4) : ADDR_W'(0));
        first_be = drop_lo ? be_first[7:4] : be_first[3:0];
        if (len_dw == LEN_W'(1)) begin
            last_be = 4'h0;
        end else if (drop_hi) begin
            last_be = be_end[3:0];
        end else begin
            last_be = be_end[7:4];
        end
        hdr4 = |pkt_addr[ADDR_W-1:32];
    end
endmodule

// File: rtl/pcie_write_segmenter.sv
module pcie_write_segmenter
    import pcie_wseg_pkg::*;
#(
    parameter int ADDR_W          = 64,
    parameter int MAX_BURST_BYTES = 512,
    parameter int BOUND_BYTES     = 4096,
    parameter int LEN_W           = 10,
    localparam int QA_W      = ADDR_W - 3,
    localparam int MAX_BEATS = MAX_BURST_BYTES / QW_BE,
    localparam int CNT_W     = $clog2(MAX_BEATS) + 1,
    localparam int IDX_W     = $clog2(MAX_BEATS),
    localparam int OFS_W     = $clog2(BOUND_BYTES),
    localparam int ENT_W     = QW_BITS + QW_BE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               avs_write,
    input  logic [QA_W-1:0]    avs_qw_address,
    input  logic [CNT_W-1:0]   avs_burstcount,
    input  logic [QW_BITS-1:0] avs_writedata,
    input  logic [QW_BE-1:0]   avs_byteenable,
    output logic               avs_waitrequest,
    input  logic [1:0]         mps_sel,
    output logic               desc_valid,
    input  logic               desc_ready,
    output logic [ADDR_W-1:0]  desc_addr,
    output logic [LEN_W-1:0]   desc_len_dw,
    output logic [3:0]         desc_first_be,
    output logic [3:0]         desc_last_be,
    output logic               desc_4dw,
    output logic               pl_valid,
    input  logic               pl_ready,
    output logic [QW_BITS-1:0] pl_data,
    output logic               pl_last,
    output logic               wr_err
);
    seg_state_e state_q, state_d;

    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  got_q;
    logic [CNT_W-1:0]  cap_q;
    logic [CNT_W-1:0]  pkt_len_q;
    logic [CNT_W-1:0]  idx_q;
    logic [IDX_W-1:0]  base_q;
    logic              bad_q;

    logic              accept;
    logic              beat_multi;
    logic              beat_last;
    logic              beat_ok;
    logic [CNT_W-1:0]  bc_eff;
    logic [CNT_W-1:0]  cap_sel;
    logic [CNT_W-1:0]  pkt_beats;
    logic              pkt_end;
    logic              final_pkt;
    logic              single;
    logic              store_we;
    logic [IDX_W-1:0]  store_waddr;
    beat_t             store_wdata;
    logic [2:0][IDX_W-1:0] rd_idx;
    logic [2:0][ENT_W-1:0] rd_ent;
    beat_t             ent_first;
    beat_t             ent_end;
    beat_t             ent_pl;

    // ---------------- beat intake ----------------
    always_comb begin
        accept = avs_write && !avs_waitrequest;
        bc_eff = (avs_burstcount == '0) ? CNT_W'(1) : avs_burstcount;
        if (state_q == ST_IDLE) begin
            beat_multi = (bc_eff > CNT_W'(1));
            beat_last  = (bc_eff == CNT_W'(1));
        end else begin
            beat_multi = 1'b1;
            beat_last  = ((got_q + CNT_W'(1)) == total_q);
        end
    end

    pcie_wseg_becheck u_becheck (
        .multi (beat_multi),
        .last  (beat_last),
        .be    (avs_byteenable),
        .ok    (beat_ok)
    );

    always_comb begin
        unique case (mps_sel)
            2'd1:    cap_sel = CNT_W'(256 / QW_BE);
            2'd2:    cap_sel = CNT_W'(512 / QW_BE);
            default: cap_sel = CNT_W'(128 / QW_BE);
        endcase
        if (cap_sel > CNT_W'(MAX_BEATS)) begin
            cap_sel = CNT_W'(MAX_BEATS);
        end
    end

    // ---------------- beat store ----------------
    always_comb begin
        store_we          = accept && ((state_q == ST_IDLE) || (state_q == ST_COLLECT));
        store_waddr       = (state_q == ST_IDLE) ? '0 : IDX_W'(got_q);
        store_wdata.be    = avs_byteenable;
        store_wdata.data  = avs_writedata;
        rd_idx[0]         = base_q;
        rd_idx[1]         = base_q + IDX_W'(pkt_beats - CNT_W'(1));
        rd_idx[2]         = base_q + IDX_W'(idx_q);
    end

    pcie_wseg_store #(
        .DEPTH (MAX_BEATS),
        .W     (ENT_W),
        .NRD   (3)
    ) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (store_waddr),
        .wdata (store_wdata),
        .raddr (rd_idx),
        .rdata (rd_ent)
    );

    assign ent_first = rd_ent[0];
    assign ent_end   = rd_ent[1];
    assign ent_pl    = rd_ent[2];

    // ---------------- packet planning ----------------
    pcie_wseg_split #(
        .CNT_W       (CNT_W),
        .BOUND_BYTES (BOUND_BYTES)
    ) u_split (
        .qw_ofs     (cur_addr_q[OFS_W-1:3]),
        .beats_left (left_q),
        .cap_beats  (cap_q),
        .pkt_beats  (pkt_beats)
    );

    always_comb begin
        final_pkt = (pkt_beats == left_q);
        single    = (total_q == CNT_W'(1));
        pkt_end   = (idx_q == (pkt_len_q - CNT_W'(1)));
    end

    pcie_wseg_desc #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W)
    ) u_desc (
        .base_addr (cur_addr_q),
        .pkt_beats (pkt_beats),
        .single    (single),
        .final_pkt (final_pkt),
        .be_first  (ent_first.be),
        .be_end    (ent_end.be),
        .pkt_addr  (desc_addr),
        .len_dw    (desc_len_dw),
        .first_be  (desc_first_be),
        .last_be   (desc_last_be),
        .hdr4      (desc_4dw)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!beat_last) begin
                        state_d = ST_COLLECT;
                    end else begin
                        state_d = beat_ok ? ST_DESC : ST_ERR;
                    end
                end
            end
            ST_COLLECT: begin
                if (accept && beat_last) begin
                    state_d = (bad_q || !beat_ok) ? ST_ERR : ST_DESC;
                end
            end
            ST_ERR: begin
                state_d = ST_IDLE;
            end
            ST_DESC: begin
                if (desc_ready) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (pl_ready && pkt_end) begin
                    state_d = (left_q == pkt_len_q) ? ST_IDLE : ST_DESC;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        avs_waitrequest = !((state_q == ST_IDLE) || (state_q == ST_COLLECT));
        desc_valid      = (state_q == ST_DESC);
        pl_valid        = (state_q == ST_DATA);
        wr_err          = (state_q == ST_ERR);
        pl_data         = ent_pl.data;
        pl_last         = pkt_end;
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            total_q    <= '0;
            left_q     <= '0;
            got_q      <= '0;
            cap_q      <= '0;
            pkt_len_q  <= '0;
            idx_q      <= '0;
            base_q     <= '0;
            bad_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_addr_q <= {avs_qw_address, 3'b000};
                        total_q    <= bc_eff;
                        left_q     <= bc_eff;
                        got_q      <= CNT_W'(1);
                        cap_q      <= cap_sel;
                        base_q     <= '0;
                        bad_q      <= !beat_ok;
                    end
                end
                ST_COLLECT: begin
                    if (accept) begin
                        got_q <= got_q + CNT_W'(1);
                        bad_q <= bad_q || !beat_ok;
                    end
                end
                ST_DESC: begin
                    if (desc_ready) begin
                        pkt_len_q <= pkt_beats;
                        idx_q     <= '0;
                    end
                end
                ST_DATA: begin
                    if (pl_ready) begin
                        if (pkt_end) begin
                            cur_addr_q <= cur_addr_q + ADDR_W'({pkt_len_q, 3'b000});
                            left_q     <= left_q - pkt_len_q;
                            base_q     <= base_q + IDX_W'(pkt_len_q);
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/pcie_wseg_checker.sv
module pcie_wseg_checker #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              avs_waitrequest,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic [ADDR_W-1:0] desc_addr,
    input logic [LEN_W-1:0]  desc_len_dw,
    input logic [3:0]        desc_first_be,
    input logic [3:0]        desc_last_be,
    input logic              pl_valid,
    input logic              pl_ready,
    input logic [63:0]       pl_data,
    input logic              pl_last,
    input logic              wr_err
);
    a_r2_no_4k_cross: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> ((32'(desc_addr[11:0]) + 32'(desc_len_dw) * 32'd4) <= 32'd4096));

    a_r3_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> ((desc_len_dw != '0) && (desc_len_dw <= LEN_W'(128))));

    a_r4_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_valid && pl_valid));

    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> !wr_err);

    a_r8_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> (!desc_valid && !pl_valid));

    a_r9_busy_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid || pl_valid || wr_err) |-> avs_waitrequest);

    a_r9_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_addr) &&
        $stable(desc_len_dw) && $stable(desc_first_be) && $stable(desc_last_be)));

    a_r9_pl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data) && $stable(pl_last)));
endmodule

bind pcie_write_segmenter pcie_wseg_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .avs_waitrequest (avs_waitrequest),
    .desc_valid      (desc_valid),
    .desc_ready      (desc_ready),
    .desc_addr       (desc_addr),
    .desc_len_dw     (desc_len_dw),
    .desc_first_be   (desc_first_be),
    .desc_last_be    (desc_last_be),
    .pl_valid        (pl_valid),
    .pl_ready        (pl_ready),
    .pl_data         (pl_data),
    .pl_last         (pl_last),
    .wr_err          (wr_err)
);

// File: tb/pcie_write_segmenter_tb.sv
`timescale 1ns/1ps
module pcie_write_segmenter_tb_top;
    typedef struct packed {
        logic [63:0] a;
        logic [9:0]  len;
        logic [3:0]  f;
        logic [3:0]  l;
        logic        h;
    } exp_desc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        avs_write = 1'b0;
    logic [60:0] avs_qw_address = '0;
    logic [6:0]  avs_burstcount = '0;
    logic [63:0] avs_writedata = '0;
    logic [7:0]  avs_byteenable = '0;
    logic        avs_waitrequest;
    logic [1:0]  mps_sel = 2'd0;
    logic        desc_valid;
    logic        desc_ready = 1'b1;
    logic [63:0] desc_addr;
    logic [9:0]  desc_len_dw;
    logic [3:0]  desc_first_be;
    logic [3:0]  desc_last_be;
    logic        desc_4dw;
    logic        pl_valid;
    logic        pl_ready = 1'b1;
    logic [63:0] pl_data;
    logic        pl_last;
    logic        wr_err;

    int checks = 0;
    int errs = 0;
    int err_exp = 0;
    int err_seen = 0;
    int burst_id = 0;
    bit stall_mode = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    exp_desc_t   dq[$];
    string       dtag[$];
    logic [64:0] pq[$];

    always #2 clk = ~clk;

    pcie_write_segmenter dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .avs_write       (avs_write),
        .avs_qw_address  (avs_qw_address),
        .avs_burstcount  (avs_burstcount),
        .avs_writedata   (avs_writedata),
        .avs_byteenable  (avs_byteenable),
        .avs_waitrequest (avs_waitrequest),
        .mps_sel         (mps_sel),
        .desc_valid      (desc_valid),
        .desc_ready      (desc_ready),
        .desc_addr       (desc_addr),
        .desc_len_dw     (desc_len_dw),
        .desc_first_be   (desc_first_be),
        .desc_last_be    (desc_last_be),
        .desc_4dw        (desc_4dw),
        .pl_valid        (pl_valid),
        .pl_ready        (pl_ready),
        .pl_data         (pl_data),
        .pl_last         (pl_last),
        .wr_err          (wr_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ready patterns, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        if (stall_mode) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            desc_ready = lfsr[0];
            pl_ready   = lfsr[2] | lfsr[5];
        end else begin
            desc_ready = 1'b1;
            pl_ready   = 1'b1;
        end
    end

    // monitor: handshakes seen at the falling edge complete at the next rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (desc_valid && desc_ready) begin
                if (dq.size() == 0) begin
                    chk(1'b0, "R4 unexpected descriptor", desc_addr, 64'h0);
                end else begin
                    exp_desc_t e;
                    string t;
                    e = dq.pop_front();
                    t = dtag.pop_front();
                    chk(desc_addr == e.a, {t, " R4 addr"}, desc_addr, e.a);
                    chk(desc_len_dw == e.len, {t, " R5 len"}, 64'(desc_len_dw), 64'(e.len));
                    chk({desc_first_be, desc_last_be} == {e.f, e.l}, {t, " R5 be"},
                        64'({desc_first_be, desc_last_be}), 64'({e.f, e.l}));
                    chk(desc_4dw == e.h, {t, " R7 hdr"}, 64'(desc_4dw), 64'(e.h));
                    chk(avs_waitrequest == 1'b1, "R9 busy while emitting", 64'(avs_waitrequest), 64'h1);
                end
            end
            if (pl_valid && pl_ready) begin
                if (pq.size() == 0) begin
                    chk(1'b0, "R4 unexpected payload", pl_data, 64'h0);
                end else begin
                    logic [64:0] p;
                    p = pq.pop_front();
                    chk(pl_data == p[63:0], "R4 payload data", pl_data, p[63:0]);
                    chk(pl_last == p[64], "R4 payload last", 64'(pl_last), 64'(p[64]));
                end
            end
            if (wr_err) begin
                err_seen++;
            end
        end
    end

    function automatic logic [7:0] be_of(input int i, input int n, input logic [7:0] bf,
                                         input logic [7:0] bm, input logic [7:0] bl);
        if (i == 0) return bf;
        if (i == n - 1) return bl;
        return bm;
    endfunction

    // driver: pushes expectations from the requirements, then drives the beats
    task automatic send_burst(input string tag, input logic [63:0] addr, input int n,
                              input logic [1:0] mps, input logic [7:0] bf,
                              input logic [7:0] bm, input logic [7:0] bl,
                              input bit bad, input int mps_later);
        int cap;
        int rem;
        int bi;
        int stalls;
        logic [63:0] a;
        burst_id++;
        if (bad) begin
            err_exp++;
        end else begin
            cap = (mps == 2'd1) ? 32 : (mps == 2'd2) ? 64 : 16;
            rem = n;
            a = addr;
            bi = 0;
            while (rem > 0) begin
                int room;
                int pb;
                logic [7:0] f8;
                logic [7:0] l8;
                bit dl;
                bit dh;
                exp_desc_t e;
                room = 512 - int'(a[11:3]);
                pb = rem;
                if (cap < pb) pb = cap;
                if (room < pb) pb = room;
                f8 = be_of(bi, n, bf, bm, bl);
                l8 = be_of(bi + pb - 1, n, bf, bm, bl);
                dl = (n == 1) && (f8[3:0] == 4'h0) && (f8[7:4] != 4'h0);
                dh = (rem == pb) && (l8[7:4] == 4'h0);
                e.len = 10'(2 * pb - int'(dl) - int'(dh));
                e.a = a + (dl ? 64'd4 : 64'd0);
                e.f = dl ? f8[7:4] : f8[3:0];
                e.l = (e.len == 10'd1) ? 4'h0 : (dh ? l8[3:0] : l8[7:4]);
                e.h = |e.a[63:32];
                dq.push_back(e);
                dtag.push_back(tag);
                for (int k = 0; k < pb; k++) begin
                    pq.push_back({(k == pb - 1), 32'(burst_id), 32'(bi + k)});
                end
                a = a + 64'(pb * 8);
                rem = rem - pb;
                bi = bi + pb;
            end
        end
        stalls = 0;
        mps_sel = mps;
        for (int i = 0; i < n; i++) begin
            avs_write      = 1'b1;
            avs_qw_address = addr[63:3];
            avs_burstcount = 7'(n);
            avs_writedata  = {32'(burst_id), 32'(i)};
            avs_byteenable = be_of(i, n, bf, bm, bl);
            forever begin
                @(negedge clk);
                if (!avs_waitrequest) break;
                if (i > 0) stalls++;
                @(posedge clk);
                #1;
            end
            @(posedge clk);
            #1;
            if (i == 0 && mps_later >= 0) mps_sel = 2'(mps_later);
        end
        avs_write = 1'b0;
        avs_byteenable = '0;
        @(negedge clk);
        if (bad) begin
            chk(wr_err == 1'b1, {tag, " R8 err pulse timing"}, 64'(wr_err), 64'h1);
            chk(stalls == 0, {tag, " R8 beats consumed"}, 64'(stalls), 64'h0);
        end else begin
            chk(desc_valid == 1'b1, {tag, " R10 descriptor timing"}, 64'(desc_valid), 64'h1);
            chk(stalls == 0, {tag, " R9 no stall mid burst"}, 64'(stalls), 64'h0);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        for (int k = 0; k < 20000 && (dq.size() != 0 || pq.size() != 0 || !(avs_waitrequest == 1'b0)); k++) begin
            @(negedge clk);
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({avs_waitrequest, desc_valid, pl_valid, wr_err} == 4'b0000, "R1 reset outputs",
            64'({avs_waitrequest, desc_valid, pl_valid, wr_err}), 64'h0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk({avs_waitrequest, desc_valid, pl_valid, wr_err} == 4'b0000, "R1 after reset",
            64'({avs_waitrequest, desc_valid, pl_valid, wr_err}), 64'h0);
        @(posedge clk);
        #1;

        send_burst("R4 basic", 64'h1000, 8, 2'd0, 8'hFF, 8'hFF, 8'hFF, 1'b0, -1);
        send_burst("R3 mps128", 64'h0, 64, 2'd0, 8'hFF, 8'hFF, 8'hFF, 1'b0, -1);
        send_burst("R3 mps512", 64'h2000, 64, 2'd2, 8'hFF, 8'hFF, 8'hFF, 1'b0, -1);
        send_burst("R3 mps256", 64'h4000, 40, 2'd1, 8'hFF, 8'hFF, 8'h0F, 1'b0, -1);
        send_burst("R3 sel3", 64'h5000, 20, 2'd3, 8'hFF, 8'hFF, 8'hFF, 1'b0, -1);
        send_burst("R3 late sel", 64'h6000, 64, 2'd0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 2);
        send_burst("R2 4k split", 64'h0FC8, 20, 2'd2, 8'hFF, 8'hFF, 8'h03, 1'b0, -1);
        send_burst("R2 4k mps", 64'h1F00, 64, 2'd2, 8'hFF, 8'hFF, 8'h7F, 1'b0, -1);
        send_burst("R5 last nib", 64'h3000, 2, 2'd0, 8'hFF, 8'hFF, 8'h01, 1'b0, -1);
        send_burst("R6 hi only", 64'h7008, 1, 2'd0, 8'hF0, 8'hFF, 8'hF0, 1'b0, -1);
        send_burst("R6 both", 64'h7010, 1, 2'd0, 8'h3C, 8'hFF, 8'h3C, 1'b0, -1);
        send_burst("R6 zero", 64'h7018, 1, 2'd0, 8'h00, 8'hFF, 8'h00, 1'b0, -1);
        send_burst("R6 lo only", 64'h7020, 1, 2'd0, 8'h06, 8'hFF, 8'h06, 1'b0, -1);
        send_burst("R7 high", 64'h0000_0012_3456_7800, 4, 2'd0, 8'hFF, 8'hFF, 8'hFF, 1'b0, -1);
        send_burst("R7 4g cross", 64'h0000_0000_FFFF_FFF8, 2, 2'd0, 8'hFF, 8'hFF, 8'hFF, 1'b0, -1);
        drain();

        send_burst("R8 first", 64'h8000, 4, 2'd0, 8'h7F, 8'hFF, 8'hFF, 1'b1, -1);
        send_burst("R8 mid", 64'h8100, 4, 2'd0, 8'hFF, 8'hEF, 8'hFF, 1'b1, -1);
        send_burst("R8 last gap", 64'h8200, 3, 2'd0, 8'hFF, 8'hFF, 8'h0E, 1'b1, -1);
        send_burst("R8 last zero", 64'h8300, 2, 2'd0, 8'hFF, 8'hFF, 8'h00, 1'b1, -1);
        send_burst("R8 recover", 64'h8400, 3, 2'd0, 8'hFF, 8'hFF, 8'h3F, 1'b0, -1);
        drain();

        stall_mode = 1'b1;
        send_burst("R9 stall a", 64'h0F80, 40, 2'd0, 8'hFF, 8'hFF, 8'h1F, 1'b0, -1);
        send_burst("R9 stall b", 64'h9000, 17, 2'd1, 8'hFF, 8'hFF, 8'hFF, 1'b0, -1);
        send_burst("R9 stall c", 64'h9800, 1, 2'd0, 8'hC0, 8'hFF, 8'hC0, 1'b0, -1);
        drain();
        stall_mode = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);

        chk(dq.size() == 0, "R4 all descriptors seen", 64'(dq.size()), 64'h0);
        chk(pq.size() == 0, "R4 all payload seen", 64'(pq.size()), 64'h0);
        chk(err_seen == err_exp, "R8 error pulse count", 64'(err_seen), 64'(err_exp));
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R4 watchdog expired: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule